// File: doc/BRIEF.md
# Virtual Page Translation and Access Fault Unit

The block maps a virtual word address onto a physical address and checks each memory access against the permissions of the page it falls in. When the core strobes a new virtual address into the block, the page-number field of that address indexes a synchronous translation table on the same clock edge. The entry read out is held next to the word offset of the address, and together they form the physical address from the following cycle on.

Each table entry carries a physical page number and three status bits: present, user-owned and write-enabled. The block only observes the request, direction and processor-mode signals; it drives none of them. On a cycle where a memory request is raised, it compares the held entry with the current mode and the write direction. If the access is not allowed, it raises a one-cycle page-fail pulse to the sequencer. A fill port writes one table entry per clock, and the new entry is seen by the next lookup of that page.

Top module: `page_xlat`

## Requirements
- R1: While reset is held and right after its release, `page_fail_o` is 0 and `phys_addr_o` is 0.
- R2: A lookup starts on the edge where `va_load_i` is 1, using `va_i[15:10]` as the page index. `phys_addr_o[17:10]` shows that page's physical page number from the next cycle on.
- R3: The word offset `va_i[9:0]` latched by a load appears unchanged on `phys_addr_o[9:0]`.
- R4: A requested access whose held entry has its present bit clear gives `page_fail_o` = 1 in the cycle after the request edge.
- R5: A requested access faults when the entry's user bit differs from `user_mode_i` (1 = user mode, 0 = executive mode).
- R6: A requested write (`mem_wr_i` = 1) faults when the entry's write-enable bit is clear. A read never faults on that bit.
- R7: With `mem_req_i` low, `page_fail_o` stays 0 whatever the held entry holds.
- R8: `page_fail_o` is a registered pulse. It is high only in the cycle after an edge with a faulting request, and it falls after an edge without a request.
- R9: A fill to a page changes nothing already looked up. `phys_addr_o` holds until the next load, and that load returns the filled entry.
- R10: When a fill and a load hit the same page on the same edge, the lookup returns the entry being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_load_i | input | 1 | Virtual address load strobe; starts a lookup |
| va_i | input | 16 | Virtual address: page [15:10], offset [9:0] |
| mem_req_i | input | 1 | Memory cycle request, one cycle per access |
| mem_wr_i | input | 1 | Direction of the requested cycle, 1 = write |
| user_mode_i | input | 1 | Current processor mode, 1 = user |
| fill_en_i | input | 1 | Table fill strobe |
| fill_page_i | input | 6 | Page index to fill |
| fill_ppn_i | input | 8 | Physical page number to store |
| fill_valid_i | input | 1 | Present bit to store |
| fill_user_i | input | 1 | User bit to store |
| fill_wr_i | input | 1 | Write-enable bit to store |
| phys_addr_o | output | 18 | Translated address {page number, offset} |
| page_fail_o | output | 1 | Page-fail pulse to the sequencer |

## Verification
A table fill and a lookup can land on the same edge for the same page. In that case the block must pick the new entry and not the stale array word. The bench provokes this by driving the fill strobe and the load strobe together for one page. It judges the result by the returned page number and by the fault caused by the new present bit. A second overlap is a fill to the page that is already held: the held translation must not move until the next load.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
  parameter int unsigned VA_W   = 16;
  parameter int unsigned PAGE_W = 6;
  parameter int unsigned PPN_W  = 8;
  localparam int unsigned OFF_W = VA_W - PAGE_W;
  localparam int unsigned PA_W  = PPN_W + OFF_W;
  localparam int unsigned DEPTH = 1 << PAGE_W;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic             valid;
    logic             user;
    logic             wr_en;
  } pte_t;
endpackage

// File: rtl/page_xlat_table.sv
module page_xlat_table
  import page_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [PAGE_W-1:0] ra_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wa_i,
  input  pte_t              wd_i,
  output pte_t              rd_o
);
  pte_t mem [DEPTH];
  logic hit;

  assign hit = we_i && (wa_i == ra_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // read on the load edge; same-edge fill forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_o <= '0;
    else if (ld_i) rd_o <= hit ? wd_i : mem[ra_i];
  end

  a_r10_fill_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && we_i && (wa_i == ra_i)) |=> (rd_o == $past(wd_i)));

  a_r9_hold_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(rd_o));
endmodule

// File: rtl/page_xlat_check.sv
module page_xlat_check
  import page_xlat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  pte_t ent_i,
  input  logic req_i,
  input  logic wr_i,
  input  logic user_i,
  output logic fail_o
);
  logic bad_access;

  always_comb begin
    bad_access = !ent_i.valid || (ent_i.user != user_i) || (wr_i && !ent_i.wr_en);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_o <= 1'b0;
    else         fail_o <= req_i && bad_access;
  end

  a_r7_idle_no_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !fail_o);

  a_r4_invalid_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ent_i.valid) |=> fail_o);

  a_r5_mode_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (ent_i.user != user_i)) |=> fail_o);

  a_r6_read_ignores_wp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wr_i && ent_i.valid && (ent_i.user == user_i)) |=> !fail_o);

  a_r6_write_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && wr_i && !ent_i.wr_en) |=> fail_o);
endmodule

// File: rtl/page_xlat.sv
module page_xlat
  import page_xlat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              va_load_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              mem_req_i,
  input  logic              mem_wr_i,
  input  logic              user_mode_i,
  input  logic              fill_en_i,
  input  logic [PAGE_W-1:0] fill_page_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              fill_valid_i,
  input  logic              fill_user_i,
  input  logic              fill_wr_i,
  output logic [PA_W-1:0]   phys_addr_o,
  output logic              page_fail_o
);
  logic [OFF_W-1:0] off_q;
  pte_t             fill_ent;
  pte_t             ent;

  assign fill_ent = '{ppn: fill_ppn_i, valid: fill_valid_i, user: fill_user_i, wr_en: fill_wr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        off_q <= '0;
    else if (va_load_i) off_q <= va_i[OFF_W-1:0];
  end

  page_xlat_table u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (va_load_i),
    .ra_i   (va_i[VA_W-1:OFF_W]),
    .we_i   (fill_en_i),
    .wa_i   (fill_page_i),
    .wd_i   (fill_ent),
    .rd_o   (ent)
  );

  page_xlat_check u_check (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ent_i  (ent),
    .req_i  (mem_req_i),
    .wr_i   (mem_wr_i),
    .user_i (user_mode_i),
    .fail_o (page_fail_o)
  );

  assign phys_addr_o = {ent.ppn, off_q};

  a_r3_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_load_i |=> (phys_addr_o[OFF_W-1:0] == $past(va_i[OFF_W-1:0])));

  a_r9_phys_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !va_load_i |=> $stable(phys_addr_o));
endmodule

// File: tb/page_xlat_bench.sv
module page_xlat_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        va_load_i = 1'b0;
  logic [15:0] va_i = '0;
  logic        mem_req_i = 1'b0;
  logic        mem_wr_i = 1'b0;
  logic        user_mode_i = 1'b0;
  logic        fill_en_i = 1'b0;
  logic [5:0]  fill_page_i = '0;
  logic [7:0]  fill_ppn_i = '0;
  logic        fill_valid_i = 1'b0;
  logic        fill_user_i = 1'b0;
  logic        fill_wr_i = 1'b0;
  logic [17:0] phys_addr_o;
  logic        page_fail_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  page_xlat u_page_xlat (.*);

  // {page, offset, mode, wr, expected fail}
  localparam logic [18:0] VEC [0:9] = '{
    {6'd0, 10'h005, 1'b0, 1'b0, 1'b0},
    {6'd0, 10'h3FF, 1'b0, 1'b1, 1'b0},
    {6'd0, 10'h100, 1'b1, 1'b0, 1'b1},
    {6'd1, 10'h001, 1'b1, 1'b0, 1'b0},
    {6'd1, 10'h002, 1'b1, 1'b1, 1'b1},
    {6'd1, 10'h003, 1'b0, 1'b0, 1'b1},
    {6'd2, 10'h010, 1'b0, 1'b0, 1'b1},
    {6'd2, 10'h011, 1'b0, 1'b1, 1'b1},
    {6'd3, 10'h2AA, 1'b1, 1'b1, 1'b0},
    {6'd3, 10'h155, 1'b0, 1'b1, 1'b1}
  };
  logic [7:0] ppn_of [0:3] = '{8'h11, 8'h22, 8'h33, 8'h44};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [5:0] pg, input logic [7:0] ppn, input logic v, input logic u, input logic w);
    @(negedge clk_i);
    fill_en_i = 1'b1; fill_page_i = pg; fill_ppn_i = ppn;
    fill_valid_i = v; fill_user_i = u; fill_wr_i = w;
    @(negedge clk_i);
    fill_en_i = 1'b0;
  endtask

  task automatic load(input logic [5:0] pg, input logic [9:0] off);
    @(negedge clk_i);
    va_load_i = 1'b1; va_i = {pg, off};
    @(negedge clk_i);
    va_load_i = 1'b0;
  endtask

  task automatic request(input logic mode, input logic wr);
    mem_req_i = 1'b1; user_mode_i = mode; mem_wr_i = wr;
    @(negedge clk_i);
    mem_req_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 fail in reset", {31'd0, page_fail_o}, 32'd0);
    chk("R1 phys in reset", {14'd0, phys_addr_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 fail after reset", {31'd0, page_fail_o}, 32'd0);
    chk("R1 phys after reset", {14'd0, phys_addr_o}, 32'd0);

    fill(6'd0, 8'h11, 1'b1, 1'b0, 1'b1);
    fill(6'd1, 8'h22, 1'b1, 1'b1, 1'b0);
    fill(6'd2, 8'h33, 1'b0, 1'b0, 1'b1);
    fill(6'd3, 8'h44, 1'b1, 1'b1, 1'b1);

    // vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 10; i++) begin
      logic [5:0] pg;
      logic [9:0] off;
      pg  = VEC[i][18:13];
      off = VEC[i][12:3];
      load(pg, off);
      chk($sformatf("R2 R3 phys vec%0d", i), {14'd0, phys_addr_o}, {14'd0, ppn_of[pg[1:0]], off});
      request(VEC[i][2], VEC[i][1]);
      chk($sformatf("R4 R5 R6 fail vec%0d", i), {31'd0, page_fail_o}, {31'd0, VEC[i][0]});
      @(negedge clk_i);
      chk($sformatf("R8 pulse end vec%0d", i), {31'd0, page_fail_o}, 32'd0);
    end

    // R7: bad entry held, no request
    load(6'd2, 10'h000);
    chk("R7 idle after load", {31'd0, page_fail_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    chk("R7 idle no fault", {31'd0, page_fail_o}, 32'd0);

    // R8: back-to-back faulting requests, then drop
    load(6'd2, 10'h001);
    mem_req_i = 1'b1; user_mode_i = 1'b0; mem_wr_i = 1'b0;
    @(negedge clk_i);
    chk("R8 first pulse", {31'd0, page_fail_o}, 32'd1);
    @(negedge clk_i);
    mem_req_i = 1'b0;
    chk("R8 held with request", {31'd0, page_fail_o}, 32'd1);
    @(negedge clk_i);
    chk("R8 falls", {31'd0, page_fail_o}, 32'd0);

    // R9: refill the held page without reload
    load(6'd0, 10'h0AB);
    chk("R9 before refill", {14'd0, phys_addr_o}, {14'd0, 8'h11, 10'h0AB});
    fill(6'd0, 8'h99, 1'b1, 1'b0, 1'b0);
    chk("R9 held after refill", {14'd0, phys_addr_o}, {14'd0, 8'h11, 10'h0AB});
    request(1'b0, 1'b1);
    chk("R9 old entry still writable", {31'd0, page_fail_o}, 32'd0);
    load(6'd0, 10'h0AB);
    chk("R9 new entry after reload", {14'd0, phys_addr_o}, {14'd0, 8'h99, 10'h0AB});
    request(1'b0, 1'b1);
    chk("R9 R6 new entry write protected", {31'd0, page_fail_o}, 32'd1);

    // R10: fill and load same page on same edge
    @(negedge clk_i);
    fill_en_i = 1'b1; fill_page_i = 6'd3; fill_ppn_i = 8'h77;
    fill_valid_i = 1'b0; fill_user_i = 1'b1; fill_wr_i = 1'b1;
    va_load_i = 1'b1; va_i = {6'd3, 10'h3C3};
    @(negedge clk_i);
    fill_en_i = 1'b0; va_load_i = 1'b0;
    chk("R10 forwarded ppn", {14'd0, phys_addr_o}, {14'd0, 8'h77, 10'h3C3});
    request(1'b1, 1'b0);
    chk("R10 R4 forwarded invalid", {31'd0, page_fail_o}, 32'd1);

    @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule